// File: doc/BRIEF.md
# NAND Flash Identification Engine

This block brings up an attached NAND flash device on its own once it is told to start. It drives a byte-wide command/address/read-strobe interface and watches the device's ready line. It first resets the device and polls the device status until the device reports ready. It then reads the identification area twice: once to find out whether the device carries the four-byte signature of the open standard parameter format, and once to collect the manufacturer and device codes.

When the signature is present, the engine fetches the full parameter page. It runs a CRC over the page and checks the result against the integrity word stored at the end of the page. If the check passes, it decodes the geometry (page, spare, block and unit sizes, address cycle counts, bus width and an extended-page flag) and multiplies out the block and total byte counts. Surrounding logic starts the engine once after power-up, waits for `done`, and then reads the result from steady outputs that hold until the next start.

Top module: `flash_probe`

## Requirements
- R1: After reset, busy, done, onfi, geom_valid, crc_err, both ID outputs, every geometry output and every bus strobe are 0.
- R2: A start pulse seen while idle makes the next cycle a command strobe carrying 0xFF (device reset). A start pulse seen while busy is ignored, so no second reset command is issued.
- R3: After the reset command the engine repeats status polls until status bit 6 reads 1, then moves on. Each poll is command 0x70 followed by one read strobe.
- R4: The signature check is command 0x90, address 0x20 and four reads. onfi becomes 1 only if the four bytes are 0x4F, 0x4E, 0x46, 0x49 in that order.
- R5: Identification is command 0x90, address 0x00 and two reads. The first byte goes to mfr_id and the second to dev_id.
- R6: When onfi is set, the engine issues command 0xEC with address 0x00 and waits for fl_rdy to be 1. It then issues exactly 256 read strobes and never strobes a read while fl_rdy is 0.
- R7: The CRC covers bytes 0 to 253 with polynomial 0x8005, start value 0x4F4E, most significant bit first and no final inversion. It is compared with the word stored at byte 254 (low) and byte 255 (high). A mismatch gives crc_err=1 and geom_valid=0, and geom_valid and crc_err are never both 1.
- R8: Multi-byte fields are little-endian. Page size comes from bytes 80..83, spare size from bytes 84..85, pages per block from bytes 92..95, blocks per unit from bytes 96..99 and unit count from byte 100.
- R9: Byte 101 gives row_cyc from its bits 2..0 and col_cyc from its bits 7..4.
- R10: The feature word at bytes 6..7 drives bus16 from bit 0 and ext_pg from bit 7.
- R11: blk_bytes equals page size times pages per block. dev_bytes equals blk_bytes times blocks per unit times unit count. Both are taken modulo 2^64.
- R12: For a device without the signature, no 0xEC command is issued and geom_valid and crc_err stay 0. All geometry outputs read 0, while mfr_id and dev_id are still reported. geom_valid is never 1 without onfi.
- R13: done is a one-cycle pulse at the end of a probe. busy is 1 from the cycle after an accepted start until done rises.
- R14: In any cycle at most one of fl_cmd_we, fl_addr_we and fl_rd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (single-cycle pulse) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| fl_cmd_we | output | 1 | Command byte strobe |
| fl_addr_we | output | 1 | Address byte strobe |
| fl_rd | output | 1 | Read strobe; fl_din sampled in the same cycle |
| fl_dout | output | 8 | Command or address byte |
| fl_din | input | 8 | Byte returned by the device |
| fl_rdy | input | 1 | Device ready (1) or busy (0) |
| onfi | output | 1 | Signature found |
| geom_valid | output | 1 | Parameter page passed CRC; geometry valid |
| crc_err | output | 1 | Parameter page CRC mismatch |
| mfr_id | output | 8 | Manufacturer code |
| dev_id | output | 8 | Device code |
| page_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_blk | output | 32 | Pages per block |
| blks_per_lun | output | 32 | Blocks per unit |
| lun_cnt | output | 8 | Number of units |
| row_cyc | output | 3 | Row address cycles |
| col_cyc | output | 4 | Column address cycles |
| bus16 | output | 1 | 16-bit data bus |
| ext_pg | output | 1 | Extended parameter page present |
| blk_bytes | output | 64 | Bytes per block |
| dev_bytes | output | 64 | Total bytes |

## Verification
Some properties are checked by the assertions on every cycle. These are the single-strobe rule, the reset command that immediately follows an accepted start, the one-cycle done pulse, a parameter-page read never starting before ready, geom_valid never coexisting with crc_err, and geom_valid never appearing without the signature. Only the bench scenarios can show the rest. That covers the byte-exact polling count, signature and ID decoding, CRC acceptance and rejection, little-endian field placement, the size products and the legacy path. The bench checks these against a modelled device whose status delay, busy time, signature and page contents vary from run to run.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_RST, S_STC, S_STR,
      S_SGC,  S_SGA, S_SGR,
      S_IDC,  S_IDA, S_IDR,
      S_PPC,  S_PPA, S_PPW, S_PPR,
      S_FIN
   } probe_state_e;

   // signature bytes, first byte read in the low lane
   localparam logic [31:0] SIG_WORD = {8'h49, 8'h46, 8'h4E, 8'h4F};

   function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                              input logic [7:0]  data,
                                              input logic [15:0] poly);
      logic [15:0] c;
      logic        fb;
      c = cur;
      for (int i = 7; i >= 0; i--) begin
         fb = c[15] ^ data[i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

endpackage

// File: rtl/fprb_crc16.sv
module fprb_crc16 #(
   parameter logic [15:0] POLY = 16'h8005,
   parameter logic [15:0] INIT = 16'h4F4E
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import flash_probe_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)      crc <= INIT;
      else if (clr)    crc <= INIT;
      else if (en)     crc <= crc16_step(crc, din, POLY);
   end

endmodule

// File: rtl/fprb_le_field.sv
module fprb_le_field #(
   parameter int OFFSET = 0,
   parameter int NBYTES = 1,
   parameter int IDX_W  = 8,
   parameter int OUT_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       din,
   output logic [OUT_W-1:0] value
);
   if (NBYTES < 1 || 8 * NBYTES > OUT_W) begin : g_bad_width
      $error("fprb_le_field: NBYTES does not fit OUT_W");
   end

   logic [7:0] lane [NBYTES];

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)                                 lane[k] <= '0;
         else if (clr)                               lane[k] <= '0;
         else if (en && idx == IDX_W'(OFFSET + k))   lane[k] <= din;
      end
   end

   always_comb begin
      value = '0;
      for (int k = 0; k < NBYTES; k++) value[8*k +: 8] = lane[k];
   end

endmodule

// File: rtl/fprb_seq.sv
module fprb_seq #(
   parameter int          PAGE_LEN  = 256,
   parameter int          IDX_W     = 8,
   parameter int          RDY_BIT   = 6,
   parameter logic [7:0]  CMD_RESET = 8'hFF,
   parameter logic [7:0]  CMD_STAT  = 8'h70,
   parameter logic [7:0]  CMD_ID    = 8'h90,
   parameter logic [7:0]  CMD_PARAM = 8'hEC,
   parameter logic [7:0]  ADR_SIG   = 8'h20,
   parameter logic [7:0]  ADR_ID    = 8'h00,
   parameter logic [7:0]  ADR_PARAM = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       fl_din,
   input  logic             fl_rdy,
   input  logic             crc_ok,
   output logic             fl_cmd_we,
   output logic             fl_addr_we,
   output logic             fl_rd,
   output logic [7:0]       fl_dout,
   output logic             fld_clr,
   output logic             crc_clr,
   output logic             pp_en,
   output logic             crc_en,
   output logic [IDX_W-1:0] pp_idx,
   output logic             busy,
   output logic             done,
   output logic             onfi,
   output logic             valid,
   output logic             err,
   output logic [7:0]       mfr_id,
   output logic [7:0]       dev_id
);
   import flash_probe_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_LEN - 1);
   localparam logic [IDX_W-1:0] CRC_END  = IDX_W'(PAGE_LEN - 2);

   probe_state_e     state;
   logic [IDX_W-1:0] cnt;
   logic             sig_ok;
   logic             sig_match;

   assign sig_match = (fl_din == SIG_WORD[8*cnt[1:0] +: 8]);

   // bus decode
   always_comb begin
      fl_cmd_we  = 1'b0;
      fl_addr_we = 1'b0;
      fl_rd      = 1'b0;
      fl_dout    = 8'h00;
      case (state)
         S_RST:  begin fl_cmd_we  = 1'b1; fl_dout = CMD_RESET; end
         S_STC:  begin fl_cmd_we  = 1'b1; fl_dout = CMD_STAT;  end
         S_SGC,
         S_IDC:  begin fl_cmd_we  = 1'b1; fl_dout = CMD_ID;    end
         S_PPC:  begin fl_cmd_we  = 1'b1; fl_dout = CMD_PARAM; end
         S_SGA:  begin fl_addr_we = 1'b1; fl_dout = ADR_SIG;   end
         S_IDA:  begin fl_addr_we = 1'b1; fl_dout = ADR_ID;    end
         S_PPA:  begin fl_addr_we = 1'b1; fl_dout = ADR_PARAM; end
         S_STR,
         S_SGR,
         S_IDR,
         S_PPR:  fl_rd = 1'b1;
         default: ;
      endcase
   end

   assign busy    = (state != S_IDLE);
   assign fld_clr = (state == S_IDLE) && start;
   assign crc_clr = (state == S_PPA);
   assign pp_en   = (state == S_PPR);
   assign pp_idx  = cnt;
   assign crc_en  = pp_en && (cnt < CRC_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cnt    <= '0;
         sig_ok <= 1'b0;
         onfi   <= 1'b0;
         valid  <= 1'b0;
         err    <= 1'b0;
         done   <= 1'b0;
         mfr_id <= 8'h00;
         dev_id <= 8'h00;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               state  <= S_RST;
               onfi   <= 1'b0;
               valid  <= 1'b0;
               err    <= 1'b0;
               mfr_id <= 8'h00;
               dev_id <= 8'h00;
            end
            S_RST: state <= S_STC;
            S_STC: state <= S_STR;
            S_STR: state <= fl_din[RDY_BIT] ? S_SGC : S_STC;
            S_SGC: state <= S_SGA;
            S_SGA: begin
               state  <= S_SGR;
               cnt    <= '0;
               sig_ok <= 1'b1;
            end
            S_SGR: begin
               cnt <= cnt + 1'b1;
               if (cnt == IDX_W'(3)) begin
                  onfi  <= sig_ok && sig_match;
                  state <= S_IDC;
               end else begin
                  sig_ok <= sig_ok && sig_match;
               end
            end
            S_IDC: state <= S_IDA;
            S_IDA: begin
               state <= S_IDR;
               cnt   <= '0;
            end
            S_IDR: begin
               cnt <= cnt + 1'b1;
               if (cnt == '0) begin
                  mfr_id <= fl_din;
               end else begin
                  dev_id <= fl_din;
                  state  <= onfi ? S_PPC : S_FIN;
               end
            end
            S_PPC: state <= S_PPA;
            S_PPA: begin
               state <= S_PPW;
               cnt   <= '0;
            end
            S_PPW: if (fl_rdy) state <= S_PPR;
            S_PPR: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST_IDX) state <= S_FIN;
            end
            S_FIN: begin
               done  <= 1'b1;
               valid <= onfi && crc_ok;
               err   <= onfi && !crc_ok;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_cmd_we, fl_addr_we, fl_rd}));                         // R14
   AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (fl_cmd_we && fl_dout == CMD_RESET));         // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R13
   AST_READ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_rd && state == S_PPR && $past(state) == S_PPW) |-> $past(fl_rdy)); // R6
   AST_VALID_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && err));                                                  // R7
   AST_VALID_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> onfi);                                                   // R12

endmodule

// File: rtl/flash_probe.sv
module flash_probe #(
   parameter int          PAGE_LEN  = 256,
   parameter int          SZ_W      = 64,
   parameter int          RDY_BIT   = 6,
   parameter logic [15:0] CRC_POLY  = 16'h8005,
   parameter logic [15:0] CRC_INIT  = 16'h4F4E,
   parameter logic [7:0]  CMD_RESET = 8'hFF,
   parameter logic [7:0]  CMD_STAT  = 8'h70,
   parameter logic [7:0]  CMD_ID    = 8'h90,
   parameter logic [7:0]  CMD_PARAM = 8'hEC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            busy,
   output logic            done,
   output logic            fl_cmd_we,
   output logic            fl_addr_we,
   output logic            fl_rd,
   output logic [7:0]      fl_dout,
   input  logic [7:0]      fl_din,
   input  logic            fl_rdy,
   output logic            onfi,
   output logic            geom_valid,
   output logic            crc_err,
   output logic [7:0]      mfr_id,
   output logic [7:0]      dev_id,
   output logic [31:0]     page_bytes,
   output logic [15:0]     spare_bytes,
   output logic [31:0]     pages_per_blk,
   output logic [31:0]     blks_per_lun,
   output logic [7:0]      lun_cnt,
   output logic [2:0]      row_cyc,
   output logic [3:0]      col_cyc,
   output logic            bus16,
   output logic            ext_pg,
   output logic [SZ_W-1:0] blk_bytes,
   output logic [SZ_W-1:0] dev_bytes
);
   localparam int IDX_W = $clog2(PAGE_LEN);
   localparam int NF    = 8;
   localparam int F_FEAT = 0, F_PAGE = 1, F_SPARE = 2, F_PPB = 3,
                  F_BPL  = 4, F_LUNS = 5, F_ACYC  = 6, F_CRC = 7;
   localparam int F_OFF [NF] = '{6, 80, 84, 92, 96, 100, 101, PAGE_LEN - 2};
   localparam int F_LEN [NF] = '{2, 4, 2, 4, 4, 1, 1, 2};

   if (PAGE_LEN < 128 || PAGE_LEN > 4096 || (PAGE_LEN & (PAGE_LEN - 1)) != 0) begin : g_bad_len
      $error("flash_probe: PAGE_LEN must be a power of two from 128 to 4096");
   end
   if (SZ_W < 32) begin : g_bad_sz
      $error("flash_probe: SZ_W must be at least 32");
   end
   if (RDY_BIT < 0 || RDY_BIT > 7) begin : g_bad_rdy
      $error("flash_probe: RDY_BIT out of range");
   end

   logic             fld_clr, crc_clr, pp_en, crc_en, crc_ok;
   logic [IDX_W-1:0] pp_idx;
   logic [15:0]      crc_val;
   logic [31:0]      fv [NF];

   fprb_seq #(
      .PAGE_LEN (PAGE_LEN), .IDX_W (IDX_W), .RDY_BIT (RDY_BIT),
      .CMD_RESET(CMD_RESET), .CMD_STAT(CMD_STAT),
      .CMD_ID   (CMD_ID),    .CMD_PARAM(CMD_PARAM),
      .ADR_SIG  (8'h20), .ADR_ID(8'h00), .ADR_PARAM(8'h00)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .fl_din    (fl_din),
      .fl_rdy    (fl_rdy),
      .crc_ok    (crc_ok),
      .fl_cmd_we (fl_cmd_we),
      .fl_addr_we(fl_addr_we),
      .fl_rd     (fl_rd),
      .fl_dout   (fl_dout),
      .fld_clr   (fld_clr),
      .crc_clr   (crc_clr),
      .pp_en     (pp_en),
      .crc_en    (crc_en),
      .pp_idx    (pp_idx),
      .busy      (busy),
      .done      (done),
      .onfi      (onfi),
      .valid     (geom_valid),
      .err       (crc_err),
      .mfr_id    (mfr_id),
      .dev_id    (dev_id)
   );

   fprb_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .en   (crc_en),
      .din  (fl_din),
      .crc  (crc_val)
   );

   for (genvar f = 0; f < NF; f++) begin : g_field
      fprb_le_field #(
         .OFFSET(F_OFF[f]), .NBYTES(F_LEN[f]), .IDX_W(IDX_W), .OUT_W(32)
      ) u_fld (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (fld_clr),
         .en   (pp_en),
         .idx  (pp_idx),
         .din  (fl_din),
         .value(fv[f])
      );
   end

   assign crc_ok = (crc_val == fv[F_CRC][15:0]);

   // geometry is exposed only once the page is trusted
   always_comb begin
      page_bytes    = '0;
      spare_bytes   = '0;
      pages_per_blk = '0;
      blks_per_lun  = '0;
      lun_cnt       = '0;
      row_cyc       = '0;
      col_cyc       = '0;
      bus16         = 1'b0;
      ext_pg        = 1'b0;
      if (geom_valid) begin
         page_bytes    = fv[F_PAGE];
         spare_bytes   = fv[F_SPARE][15:0];
         pages_per_blk = fv[F_PPB];
         blks_per_lun  = fv[F_BPL];
         lun_cnt       = fv[F_LUNS][7:0];
         row_cyc       = fv[F_ACYC][2:0];
         col_cyc       = fv[F_ACYC][7:4];
         bus16         = fv[F_FEAT][0];
         ext_pg        = fv[F_FEAT][7];
      end
   end

   assign blk_bytes = SZ_W'(page_bytes) * SZ_W'(pages_per_blk);
   assign dev_bytes = blk_bytes * SZ_W'(blks_per_lun) * SZ_W'(lun_cnt);

endmodule

// File: tb/flash_probe_tb_top.sv
module flash_probe_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, fl_cmd_we, fl_addr_we, fl_rd;
   logic [7:0]  fl_dout, fl_din;
   logic        fl_rdy;
   logic        onfi, geom_valid, crc_err, bus16, ext_pg;
   logic [7:0]  mfr_id, dev_id, lun_cnt;
   logic [31:0] page_bytes, pages_per_blk, blks_per_lun;
   logic [15:0] spare_bytes;
   logic [2:0]  row_cyc;
   logic [3:0]  col_cyc;
   logic [63:0] blk_bytes, dev_bytes;

   always #4 clk = ~clk;   // 125 MHz

   flash_probe dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fl_cmd_we(fl_cmd_we), .fl_addr_we(fl_addr_we), .fl_rd(fl_rd),
      .fl_dout(fl_dout), .fl_din(fl_din), .fl_rdy(fl_rdy),
      .onfi(onfi), .geom_valid(geom_valid), .crc_err(crc_err),
      .mfr_id(mfr_id), .dev_id(dev_id), .page_bytes(page_bytes),
      .spare_bytes(spare_bytes), .pages_per_blk(pages_per_blk),
      .blks_per_lun(blks_per_lun), .lun_cnt(lun_cnt), .row_cyc(row_cyc),
      .col_cyc(col_cyc), .bus16(bus16), .ext_pg(ext_pg),
      .blk_bytes(blk_bytes), .dev_bytes(dev_bytes)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   typedef enum logic [2:0] {M_NONE, M_STAT, M_IDW, M_SIG, M_ID, M_PPW, M_PP} mmode_e;

   logic [7:0]  m_pg [256];
   logic [7:0]  m_sig [4];
   logic [7:0]  m_mfr, m_dev;
   int          m_polls, m_delay;
   logic        m_clr = 1'b0;

   mmode_e      mode;
   logic [8:0]  ptr;
   int          stat_reads, pp_reads, bad_reads, rst_cmds, ec_cmds, ncmds, bcnt;
   logic [7:0]  first_cmd;
   logic        rdy_r;

   assign fl_rdy = rdy_r;

   always @(posedge clk) begin
      if (m_clr) begin
         mode <= M_NONE; ptr <= '0; stat_reads <= 0; pp_reads <= 0;
         bad_reads <= 0; rst_cmds <= 0; ec_cmds <= 0; ncmds <= 0;
         first_cmd <= 8'h00; rdy_r <= 1'b1; bcnt <= 0;
      end else begin
         if (bcnt != 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) rdy_r <= 1'b1;
         end
         if (fl_cmd_we) begin
            ncmds <= ncmds + 1;
            if (ncmds == 0) first_cmd <= fl_dout;
            case (fl_dout)
               8'hFF: begin mode <= M_NONE; rst_cmds <= rst_cmds + 1; end
               8'h70: mode <= M_STAT;
               8'h90: mode <= M_IDW;
               8'hEC: begin mode <= M_PPW; ec_cmds <= ec_cmds + 1; end
               default: mode <= M_NONE;
            endcase
         end
         if (fl_addr_we) begin
            ptr <= '0;
            if (mode == M_IDW)
               mode <= (fl_dout == 8'h20) ? M_SIG : (fl_dout == 8'h00) ? M_ID : M_NONE;
            else if (mode == M_PPW && fl_dout == 8'h00) begin
               mode <= M_PP;
               if (m_delay != 0) begin rdy_r <= 1'b0; bcnt <= m_delay; end
            end else mode <= M_NONE;
         end
         if (fl_rd) begin
            ptr <= ptr + 1'b1;
            if (mode == M_STAT) stat_reads <= stat_reads + 1;
            if (mode == M_PP) begin
               pp_reads <= pp_reads + 1;
               if (!rdy_r) bad_reads <= bad_reads + 1;
            end
         end
      end
   end

   always_comb begin
      case (mode)
         M_STAT:  fl_din = (stat_reads >= m_polls) ? 8'h40 : 8'h00;
         M_SIG:   fl_din = (ptr < 9'd4) ? m_sig[ptr[1:0]] : 8'h00;
         M_ID:    fl_din = (ptr == 9'd0) ? m_mfr : (ptr == 9'd1) ? m_dev : 8'h00;
         M_PP:    fl_din = m_pg[ptr[7:0]];
         default: fl_din = 8'h00;
      endcase
   end

   // ---------------- reference functions ----------------
   function automatic logic [15:0] ref_crc(input int nbytes);
      logic [15:0] r = 16'h4F4E;
      for (int i = 0; i < nbytes; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic top = r[15] ^ m_pg[i][b];
            r = r << 1;
            if (top) r = r ^ 16'h8005;
         end
      end
      return r;
   endfunction

   logic [31:0] e_psz, e_ppb, e_bpl;
   logic [15:0] e_ssz, e_feat;
   logic [7:0]  e_luns, e_acyc;

   task automatic build_page(input logic [31:0] psz, input logic [15:0] ssz,
                             input logic [31:0] ppb, input logic [31:0] bpl,
                             input logic [7:0] luns, input logic [7:0] acyc,
                             input logic [15:0] feat, input bit bad_crc);
      logic [15:0] c;
      e_psz = psz; e_ssz = ssz; e_ppb = ppb; e_bpl = bpl;
      e_luns = luns; e_acyc = acyc; e_feat = feat;
      for (int i = 0; i < 256; i++) m_pg[i] = 8'($urandom);
      m_pg[0] = 8'h4F; m_pg[1] = 8'h4E; m_pg[2] = 8'h46; m_pg[3] = 8'h49;
      m_pg[6] = feat[7:0]; m_pg[7] = feat[15:8];
      for (int k = 0; k < 4; k++) begin
         m_pg[80 + k] = psz[8*k +: 8];
         m_pg[92 + k] = ppb[8*k +: 8];
         m_pg[96 + k] = bpl[8*k +: 8];
      end
      m_pg[84] = ssz[7:0]; m_pg[85] = ssz[15:8];
      m_pg[100] = luns; m_pg[101] = acyc;
      c = ref_crc(254);
      m_pg[254] = c[7:0]; m_pg[255] = c[15:8];
      if (bad_crc) m_pg[254] = m_pg[254] ^ 8'h01;
   endtask

   task automatic set_sig(input logic [31:0] s);
      for (int k = 0; k < 4; k++) m_sig[k] = s[31 - 8*k -: 8];
   endtask

   // ---------------- one probe ----------------
   task automatic run_case(input string nm, input int polls, input int dly,
                           input bit exp_onfi, input bit bad_crc, input bit mid_start);
      int t;
      bit ev;
      logic [63:0] eb, et;
      m_polls = polls; m_delay = dly;
      m_mfr = 8'($urandom); m_dev = 8'($urandom);
      @(negedge clk); m_clr = 1'b1;
      @(negedge clk); m_clr = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk({nm, " R13 busy after start"}, busy, 1);
      if (mid_start) begin
         repeat (6) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      chk({nm, " R13 done reached"}, done, 1);
      chk({nm, " R13 busy low at done"}, busy, 0);
      ev = exp_onfi && !bad_crc;
      chk({nm, " R2 first command"}, first_cmd, 8'hFF);
      chk({nm, " R2 single reset"}, rst_cmds, 1);
      chk({nm, " R3 status polls"}, stat_reads, polls + 1);
      chk({nm, " R4 onfi"}, onfi, exp_onfi);
      chk({nm, " R5 mfr"}, mfr_id, m_mfr);
      chk({nm, " R5 dev"}, dev_id, m_dev);
      chk({nm, " R6 page reads"}, pp_reads, exp_onfi ? 256 : 0);
      chk({nm, " R6 reads while busy"}, bad_reads, 0);
      chk({nm, " R12 param cmds"}, ec_cmds, exp_onfi ? 1 : 0);
      chk({nm, " R7 valid"}, geom_valid, ev);
      chk({nm, " R7 crc_err"}, crc_err, exp_onfi && bad_crc);
      chk({nm, " R8 page"}, page_bytes, ev ? e_psz : 0);
      chk({nm, " R8 spare"}, spare_bytes, ev ? e_ssz : 0);
      chk({nm, " R8 ppb"}, pages_per_blk, ev ? e_ppb : 0);
      chk({nm, " R8 bpl"}, blks_per_lun, ev ? e_bpl : 0);
      chk({nm, " R8 luns"}, lun_cnt, ev ? e_luns : 0);
      chk({nm, " R9 row"}, row_cyc, ev ? e_acyc[2:0] : 0);
      chk({nm, " R9 col"}, col_cyc, ev ? e_acyc[7:4] : 0);
      chk({nm, " R10 bus16"}, bus16, ev ? e_feat[0] : 0);
      chk({nm, " R10 ext"}, ext_pg, ev ? e_feat[7] : 0);
      eb = ev ? 64'(e_psz) * 64'(e_ppb) : 64'd0;
      et = eb * 64'(e_bpl) * 64'(e_luns);
      chk({nm, " R11 block"}, blk_bytes, eb);
      chk({nm, " R11 total"}, dev_bytes, et);
      @(negedge clk);
      chk({nm, " R13 done pulse"}, done, 0);
      chk({nm, " R12 result held"}, geom_valid, ev);
   endtask

   initial begin
      void'($urandom(32'd1789));
      m_polls = 0; m_delay = 0; m_mfr = 0; m_dev = 0;
      for (int i = 0; i < 256; i++) m_pg[i] = 8'h00;
      set_sig(32'h4F4E4649);
      m_clr = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1; m_clr = 1'b0;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 strobes", {fl_cmd_we, fl_addr_we, fl_rd}, 0);
      chk("R1 onfi/valid/err", {onfi, geom_valid, crc_err}, 0);
      chk("R1 ids", {mfr_id, dev_id}, 0);
      chk("R1 geometry", dev_bytes | blk_bytes | page_bytes, 0);

      set_sig(32'h4F4E4649);
      build_page(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1, 8'h23, 16'h0081, 1'b0);
      run_case("directed", 0, 0, 1'b1, 1'b0, 1'b0);

      build_page(32'd16384, 16'd1216, 32'd512, 32'hFFFF_0000, 8'd255, 8'hF7, 16'h0000, 1'b0);
      run_case("slow", 3, 7, 1'b1, 1'b0, 1'b0);

      build_page(32'd4096, 16'd224, 32'd128, 32'd2048, 8'd2, 8'h35, 16'h0001, 1'b1);
      run_case("badcrc R7", 1, 2, 1'b1, 1'b1, 1'b0);

      set_sig(32'h4F4E464A);
      build_page(32'd4096, 16'd224, 32'd128, 32'd2048, 8'd2, 8'h35, 16'h0001, 1'b0);
      run_case("nearsig R12", 0, 0, 1'b0, 1'b0, 1'b0);

      set_sig(32'h4C454759);
      run_case("legacy R12", 2, 0, 1'b0, 1'b0, 1'b0);

      set_sig(32'h4F4E4649);
      build_page(32'd8192, 16'd448, 32'd256, 32'd4096, 8'd4, 8'h24, 16'h0080, 1'b0);
      run_case("midstart R2", 0, 3, 1'b1, 1'b0, 1'b1);

      for (int n = 0; n < 6; n++) begin
         build_page(32'd512 << ($urandom % 6), 16'($urandom % 1024),
                    32'd32 << ($urandom % 4), 32'($urandom), 8'($urandom),
                    8'($urandom), 16'($urandom), 1'b0);
         run_case("random", int'($urandom % 4), int'($urandom % 9), 1'b1, 1'b0, 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R13 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule